// File: doc/BRIEF.md
# Stereo Serial Sample Formatter

This block turns parallel stereo samples into two serial data streams, one for the left channel and one for the right. Both streams share one bit clock and one word clock. Every word period it takes a fresh left and right sample from its parallel inputs, trims each one to the selected word length, and optionally recodes it. It then sends both samples most significant bit first, each inside a fixed 20-bit slot. The system clock runs at a fixed multiple of the sample rate. A rate select input sets how many system clocks make up one bit period.

The timing counters start only after an edge of the incoming left/right clock. After a reset the outputs stay idle until the first rising edge of `lr_in`. The block then starts its first word on that edge. There are two synchronisation modes. In jitter-free mode the block locks to that first edge and runs freely from then on; a new reset is needed to realign it. In forced-follow mode every rising edge of `lr_in` starts a new word at once.

Top module: `sao_fmt_top`

## Requirements
- R1: While `rst` is high, and afterwards until the first rising edge of `lr_in`, the outputs `bck_o`, `wck_o`, `dl_o` and `dr_o` are all low. This holds in both synchronisation modes.
- R2: A rising edge of `lr_in` ends the idle state. The first rising edge is the first clock at which `lr_in` is sampled high after being sampled low. `wck_o` toggles on that same clock edge and the first bit period starts there.
- R3: A word is 20 bit periods long. A bit period is 24 system clocks when `rate_sel`=0 and 32 when `rate_sel`=1. `bck_o` is low for the first half of each bit period and high for the second half. `wck_o` toggles once per word, and only while `bck_o` is low.
- R4: The serial data changes only at the start of a bit period, and stays stable while `bck_o` is high. Each slot is sent with slot position 0 first.
- R5: `wl_sel` selects the word length n: 0 gives 16, 1 gives 18, and 2 or 3 gives 20. The first 20−n slot positions are filler and are driven low. The following n positions carry the top n bits of the 20-bit input sample, most significant first.
- R6: `code_sel`=0 sends the trimmed word in two's complement. `code_sel`=1 sends it in complemented offset binary: every bit of the trimmed word is inverted except its most significant bit.
- R7: `dl_o` carries the word taken from `left_in` and `dr_o` the word taken from `right_in`. Both are sent in the same slot.
- R8: `left_in`, `right_in`, `wl_sel`, `code_sel` and `rate_sel` are sampled only on the clock edge that starts a word. Changing them during a word has no effect on that word.
- R9: In jitter-free mode (`sync_mode`=0), rising edges of `lr_in` after the alignment edge are ignored. The running word keeps its full length and content.
- R10: In forced-follow mode (`sync_mode`=1), every rising edge of `lr_in` abandons the running word. A new word starts on that clock edge, with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; re-arms alignment to `lr_in` |
| lr_in | input | 1 | Incoming left/right clock, synchronous to `clk` |
| sync_mode | input | 1 | 0 = jitter-free (lock once), 1 = forced-follow (restart on every edge) |
| rate_sel | input | 1 | Bit period select: 0 = 24 clocks, 1 = 32 clocks |
| wl_sel | input | 2 | Word length select: 0 = 16, 1 = 18, 2/3 = 20 bits |
| code_sel | input | 1 | 0 = two's complement, 1 = complemented offset binary |
| left_in | input | 20 | Left channel parallel sample, left-aligned |
| right_in | input | 20 | Right channel parallel sample, left-aligned |
| bck_o | output | 1 | Bit clock |
| wck_o | output | 1 | Word clock, toggles each word |
| dl_o | output | 1 | Left serial data |
| dr_o | output | 1 | Right serial data |

## Verification
The bench builds the block with its default values: a 20-bit slot and bit periods of 24 and 32 clocks. Every word therefore lasts 480 or 640 clocks. That keeps fifty-odd complete words, all word length and code combinations, and both rates within a short run. With these values, the bench can rebuild each word from the bit clock. It measures the bit and word periods exactly, and it can place `lr_in` edges at chosen points inside a word. This exercises the ignore and restart behaviour of the two synchronisation modes.

// File: rtl/sao_pkg.sv
package sao_pkg;

  localparam int unsigned CH_N = 2;

  // Number of data bits carried in a slot of slot_w positions for a word length code.
  function automatic int unsigned word_bits(input logic [1:0] sel, input int unsigned slot_w);
    case (sel)
      2'd0:    return slot_w - 4;
      2'd1:    return slot_w - 2;
      default: return slot_w;
    endcase
  endfunction

endpackage

// File: rtl/sao_timing.sv
module sao_timing #(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned DIV_LO = 24,
  parameter int unsigned DIV_HI = 32,
  localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO,
  localparam int unsigned CW = $clog2(DIV_MAX),
  localparam int unsigned BW = $clog2(SLOT_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_in,
  input  logic          sync_mode,
  input  logic          rate_sel,
  output logic          start,
  output logic          adv,
  output logic          bck_o,
  output logic [BW-1:0] bit_q
);

  logic          lr_q;
  logic          armed_q;
  logic [CW-1:0] cyc_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_nxt;
  logic          lr_rise;
  logic          at_end;
  logic          wrap;

  always_comb begin
    lr_rise = lr_in & ~lr_q;
    at_end  = (cyc_q == lim_q);
    wrap    = !armed_q && at_end && (bit_q == BW'(SLOT_W - 1));
    start   = (lr_rise && (armed_q || sync_mode)) || wrap;
    adv     = !armed_q && at_end && !start;
    lim_nxt = rate_sel ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  end

  always_ff @(posedge clk) begin
    lr_q <= lr_in;
    if (rst) begin
      armed_q <= 1'b1;
      cyc_q   <= '0;
      bit_q   <= '0;
      lim_q   <= CW'(DIV_LO - 1);
      bck_o   <= 1'b0;
    end else if (start) begin
      armed_q <= 1'b0;
      cyc_q   <= '0;
      bit_q   <= '0;
      lim_q   <= lim_nxt;
      bck_o   <= 1'b0;
    end else if (!armed_q) begin
      if (at_end) begin
        cyc_q <= '0;
        bit_q <= bit_q + 1'b1;
        bck_o <= 1'b0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
        bck_o <= (cyc_q + 1'b1) > (lim_q >> 1);
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (!bck_o && bit_q == '0 && cyc_q == '0)); // R1

  AST_JF_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && !armed_q && lr_rise && bit_q != '0 && bit_q != BW'(SLOT_W - 1))
      |=> (bit_q != '0)); // R9

  AST_CS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && lr_rise) |=> (bit_q == '0 && cyc_q == '0 && !bck_o)); // R10

endmodule

// File: rtl/sao_shift.sv
module sao_shift
  import sao_pkg::*;
#(
  parameter int unsigned SLOT_W = 20,
  localparam int unsigned BW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic [SLOT_W-1:0] sample,
  input  logic [1:0]        wl_sel,
  input  logic              code_sel,
  input  logic [BW-1:0]     bit_idx,
  output logic              dat_o
);

  logic [SLOT_W-1:0] coded;
  logic [SLOT_W-1:0] loaded;
  logic [SLOT_W-1:0] sh_q;
  logic [BW-1:0]     fill_q;
  int unsigned       n_sel;

  always_comb begin
    coded  = code_sel ? {sample[SLOT_W-1], ~sample[SLOT_W-2:0]} : sample;
    n_sel  = word_bits(wl_sel, SLOT_W);
    loaded = coded >> (SLOT_W - n_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      fill_q <= '0;
      dat_o  <= 1'b0;
    end else if (start) begin
      dat_o  <= loaded[SLOT_W-1];
      sh_q   <= {loaded[SLOT_W-2:0], 1'b0};
      fill_q <= BW'(SLOT_W - n_sel);
    end else if (adv) begin
      dat_o  <= sh_q[SLOT_W-1];
      sh_q   <= {sh_q[SLOT_W-2:0], 1'b0};
    end
  end

  AST_FILLER_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_idx < fill_q) |-> !dat_o); // R5

endmodule

// File: rtl/sao_fmt_top.sv
module sao_fmt_top
  import sao_pkg::*;
#(
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned DIV_LO = 24,
  parameter int unsigned DIV_HI = 32,
  localparam int unsigned BW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_in,
  input  logic              sync_mode,
  input  logic              rate_sel,
  input  logic [1:0]        wl_sel,
  input  logic              code_sel,
  input  logic [SLOT_W-1:0] left_in,
  input  logic [SLOT_W-1:0] right_in,
  output logic              bck_o,
  output logic              wck_o,
  output logic              dl_o,
  output logic              dr_o
);

  logic              start;
  logic              adv;
  logic [BW-1:0]     bit_q;
  logic [SLOT_W-1:0] samp [CH_N];
  logic [CH_N-1:0]   dat;

  assign samp[0] = left_in;
  assign samp[1] = right_in;

  sao_timing #(.SLOT_W(SLOT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_tim (
    .clk       (clk),
    .rst       (rst),
    .lr_in     (lr_in),
    .sync_mode (sync_mode),
    .rate_sel  (rate_sel),
    .start     (start),
    .adv       (adv),
    .bck_o     (bck_o),
    .bit_q     (bit_q)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    sao_shift #(.SLOT_W(SLOT_W)) u_sh (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .adv      (adv),
      .sample   (samp[c]),
      .wl_sel   (wl_sel),
      .code_sel (code_sel),
      .bit_idx  (bit_q),
      .dat_o    (dat[c])
    );
  end

  assign dl_o = dat[0];
  assign dr_o = dat[1];

  always_ff @(posedge clk) begin
    if (rst)        wck_o <= 1'b0;
    else if (start) wck_o <= ~wck_o;
  end

  AST_WCK_AT_BCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (wck_o != $past(wck_o)) |-> !bck_o); // R3

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bck_o && $past(bck_o)) |-> ($stable(dl_o) && $stable(dr_o))); // R4

endmodule

// File: tb/sao_fmt_top_tb_top.sv
`timescale 1ns/1ps
module sao_fmt_top_tb_top;

  localparam int SLOT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lr_in = 1'b0;
  logic sync_mode = 1'b0;
  logic rate_sel = 1'b0;
  logic [1:0] wl_sel = 2'd0;
  logic code_sel = 1'b0;
  logic [SLOT-1:0] left_in = '0;
  logic [SLOT-1:0] right_in = '0;
  logic bck_o, wck_o, dl_o, dr_o;

  int checks = 0;
  int errors = 0;

  logic [SLOT-1:0] cur_l, cur_r, nxt_l, nxt_r, dir_l, dir_r;
  logic [1:0] cur_wl, nxt_wl, dir_wl;
  logic cur_cs, nxt_cs, dir_cs, cur_rt, nxt_rt, dir_rt;
  logic dir_en = 1'b0;

  sao_fmt_top dut_i (
    .clk(clk), .rst(rst), .lr_in(lr_in), .sync_mode(sync_mode), .rate_sel(rate_sel),
    .wl_sel(wl_sel), .code_sel(code_sel), .left_in(left_in), .right_in(right_in),
    .bck_o(bck_o), .wck_o(wck_o), .dl_o(dl_o), .dr_o(dr_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected slot content: filler low first, then the top n bits MSB first,
  // non-MSB bits inverted for complemented offset binary (R5, R6).
  function automatic logic [SLOT-1:0] exp_slot(input logic [SLOT-1:0] s, input logic [1:0] wl,
                                               input logic cs);
    int n;
    int fill;
    logic [SLOT-1:0] e;
    n = (wl == 2'd0) ? 16 : ((wl == 2'd1) ? 18 : 20);
    fill = SLOT - n;
    e = '0;
    for (int b = fill; b < SLOT; b++) begin
      int idx = SLOT - 1 - (b - fill);
      e[SLOT-1-b] = s[idx] ^ (cs && idx != SLOT - 1);
    end
    return e;
  endfunction

  task automatic set_dir(input logic [SLOT-1:0] l, input logic [SLOT-1:0] r, input logic [1:0] wl,
                         input logic cs, input logic rt);
    dir_l = l; dir_r = r; dir_wl = wl; dir_cs = cs; dir_rt = rt; dir_en = 1'b1;
  endtask

  task automatic drive_next();
    if (dir_en) begin
      nxt_l = dir_l; nxt_r = dir_r; nxt_wl = dir_wl; nxt_cs = dir_cs; nxt_rt = dir_rt;
      dir_en = 1'b0;
    end else begin
      nxt_l = SLOT'($urandom); nxt_r = SLOT'($urandom);
      nxt_wl = 2'($urandom); nxt_cs = 1'($urandom); nxt_rt = 1'($urandom);
    end
    left_in = nxt_l; right_in = nxt_r; wl_sel = nxt_wl; code_sel = nxt_cs; rate_sel = nxt_rt;
  endtask

  task automatic idle_chk(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bck_o || wck_o || dl_o || dr_o) bad++;
    end
    chk(bad == 0, "R1 idle outputs low", bad, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!(bck_o || wck_o || dl_o || dr_o), "R1 outputs during reset",
          {bck_o, wck_o, dl_o, dr_o}, 0);
    end
    rst = 1'b0;
  endtask

  // Raise lr_in and expect wck_o to toggle on the very next clock edge (R2).
  task automatic align();
    logic w0;
    @(negedge clk);
    w0 = wck_o;
    lr_in = 1'b1;
    @(negedge clk);
    chk(wck_o != w0, "R2 first word clock edge latency", wck_o, !w0);
    lr_in = 1'b0;
    cur_l = nxt_l; cur_r = nxt_r; cur_wl = nxt_wl; cur_cs = nxt_cs; cur_rt = nxt_rt;
  endtask

  // Collect one word starting at the negedge right after a wck toggle.
  task automatic run_word(input int inject, input string ptag);
    int cnt = 0;
    int hi = 0;
    int nb = 0;
    int div;
    logic bp = 1'b0;
    logic wp;
    logic [SLOT-1:0] gl = '0;
    logic [SLOT-1:0] gr = '0;
    wp = wck_o;
    div = cur_rt ? 32 : 24;
    while (cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (wck_o != wp) break;
      if (bck_o) hi++;
      if (bck_o && !bp) begin
        gl = {gl[SLOT-2:0], dl_o};
        gr = {gr[SLOT-2:0], dr_o};
        nb++;
      end
      bp = bck_o;
      if (cnt == inject) lr_in = 1'b1;
      if (cnt == inject + 1) lr_in = 1'b0;
      if (cnt == 100) drive_next();
    end
    chk(cnt == SLOT * div, ptag, cnt, SLOT * div);
    chk(hi == SLOT * div / 2, "R3 bit clock high time", hi, SLOT * div / 2);
    chk(nb == SLOT, "R4 bits per slot", nb, SLOT);
    chk(gl == exp_slot(cur_l, cur_wl, cur_cs), "R5 R6 R7 R8 left slot", gl,
        exp_slot(cur_l, cur_wl, cur_cs));
    chk(gr == exp_slot(cur_r, cur_wl, cur_cs), "R5 R6 R7 R8 right slot", gr,
        exp_slot(cur_r, cur_wl, cur_cs));
    cur_l = nxt_l; cur_r = nxt_r; cur_wl = nxt_wl; cur_cs = nxt_cs; cur_rt = nxt_rt;
  endtask

  // Forced-follow restart k clocks into a word (R10); the port values are unchanged.
  task automatic cs_restart(input int k);
    logic w0;
    repeat (k) @(negedge clk);
    w0 = wck_o;
    lr_in = 1'b1;
    @(negedge clk);
    chk(wck_o != w0, "R10 restart on lr edge", wck_o, !w0);
    chk(!bck_o, "R10 bit clock restarts low", bck_o, 0);
    lr_in = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle_chk(60);                                  // R1 after reset, no lr edge yet

    // Jitter-free mode, directed corners then random words
    sync_mode = 1'b0;
    set_dir(20'h80001, 20'h7FFFF, 2'd0, 1'b0, 1'b0);
    drive_next();
    align();
    set_dir(20'hA5A5C, 20'h3C3C3, 2'd1, 1'b1, 1'b1);
    run_word(0, "R3 word period");
    for (int i = 0; i < 8; i++) begin
      set_dir(20'h80000 ^ SLOT'(i * 20'h1111), 20'hFFFFF ^ SLOT'(i * 20'h0F0F),
              2'(i % 4), 1'(i / 4), 1'(i % 2));
      run_word(0, "R3 word period");
    end
    for (int i = 0; i < 20; i++) run_word(0, "R3 word period");

    // Stray lr edges in jitter-free mode are ignored (R9)
    run_word(300, "R3 R9 period with stray lr edge");
    run_word(37, "R3 R9 period with stray lr edge");
    run_word(0, "R3 word period");

    // Reset mid-run, outputs quiet, realign at a new phase (R1, R2)
    repeat (123) @(negedge clk);
    do_reset();
    idle_chk(45);
    drive_next();
    align();
    for (int i = 0; i < 4; i++) run_word(0, "R3 word period");

    // Forced-follow mode
    do_reset();
    sync_mode = 1'b1;
    idle_chk(30);
    drive_next();
    align();
    run_word(0, "R3 word period");
    run_word(0, "R3 word period");
    cs_restart(57);
    for (int i = 0; i < 4; i++) run_word(0, "R3 word period");
    cs_restart(5);
    for (int i = 0; i < 8; i++) run_word(0, "R3 word period");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule